// File: doc/BRIEF.md
# Victim-Aggressor Calibration Pattern Generator

This block produces the write-data stimulus for a data-strobe delay calibration on a DDR data bus. It holds two programmable 64-bit serial patterns. The victim pattern drives one chosen bit in every byte lane, and the aggressor pattern drives the other seven bits of each lane. The two patterns are played out two bits per clock, one on the rising-edge beat and one on the falling-edge beat. A full pattern is therefore one 32-clock burst. After each burst the victim moves to the next bit of the byte, so a complete run lasts 8 × 32 clocks. All byte lanes use the same victim bit at the same time.

Software loads the four 32-bit pattern words through a simple write port. A select input chooses a fixed basic pattern instead: all-ones on every rising beat and all-zeros on every falling beat, for the same run length. A start pulse begins a run. The outputs carry a valid strobe and per-beat parallel data for every lane. A one-cycle done pulse marks the end of the run. The patterns and the mode are captured when a run starts, so register traffic during a run does not disturb it.

Top module: `calpat_gen`

## Requirements
- R1: After reset the pattern words hold: victim low word (wr_addr 0) = 0xAAAA0A05, victim high word (wr_addr 1) = 0x66669999, aggressor low word (wr_addr 2) = 0xC3C3F0F0, aggressor high word (wr_addr 3) = 0x0F0F3C3C. A 64-bit pattern is {high word, low word}.
- R2: In run clock k (k = 0..31 within a burst), dq_rise carries pattern bit 63−2k and dq_fall carries pattern bit 62−2k. Bit 63 therefore leaves first and bit 0 leaves last.
- R3: In a programmable-pattern run, bit b of every lane (bus bit lane*8+b) carries the victim bit when b equals the current victim index, and carries the aggressor bit otherwise.
- R4: Valid is high for exactly 256 consecutive clocks. The first run clock is the clock after the edge that samples start. The victim index is 0 in the first burst and increases by one after every 32 clocks, up to 7.
- R5: Done is high for exactly one clock, in the clock right after the last valid clock, with valid low.
- R6: Every byte lane carries the same data as lane 0 on both beats.
- R7: When basic_sel is high at start, every bit of dq_rise is 1 and every bit of dq_fall is 0 for the whole 256-clock run. Later changes of basic_sel do not affect the run.
- R8: Pattern word writes during a run leave the running outputs unchanged. They take effect at the next start.
- R9: A start pulse during a run is ignored. The run keeps its data and its 256-clock length.
- R10: While valid is low, dq_rise and dq_fall are all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Pattern word write strobe |
| wr_addr | input | 2 | Word select: 0 victim low, 1 victim high, 2 aggressor low, 3 aggressor high |
| wr_data | input | 32 | Word to write |
| basic_sel | input | 1 | Selects the fixed basic pattern, sampled at start |
| start | input | 1 | Starts a run when idle |
| valid | output | 1 | Beat data valid |
| done | output | 1 | One-clock end-of-run pulse |
| dq_rise | output | LANES*8 | Rising-edge beat data, lane l in bits l*8+7..l*8 |
| dq_fall | output | LANES*8 | Falling-edge beat data, same layout |

## Verification
The hardest case to reach from the ports is outside traffic that arrives in the middle of a burst. This covers a complete set of pattern writes, and a second start, both landing while the victim sits in a middle bit and the beat counter is away from any burst boundary. The stimulus issues four writes, and in another run a start pulse, at run clock 100 (victim bit 3, beat 4). It compares every beat of that run against the old patterns. The following run is then compared against the new patterns, which shows that the writes were held back rather than lost.

// File: rtl/calpat_pkg.sv
package calpat_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 32;
    localparam int PAT_W      = 2 * WORD_W;
    localparam int NUM_WORDS  = 4;
    localparam int ADDR_W     = $clog2(NUM_WORDS);
    localparam int BURST_CLKS = PAT_W / 2;
    localparam int BEAT_W     = $clog2(BURST_CLKS);
    localparam int VIC_W      = $clog2(BYTE_W);
    localparam int IDX_W      = $clog2(PAT_W);

    localparam logic [WORD_W-1:0] VIC_LO_RST = 32'hAAAA_0A05;
    localparam logic [WORD_W-1:0] VIC_HI_RST = 32'h6666_9999;
    localparam logic [WORD_W-1:0] AGG_LO_RST = 32'hC3C3_F0F0;
    localparam logic [WORD_W-1:0] AGG_HI_RST = 32'h0F0F_3C3C;

    typedef enum logic [ADDR_W-1:0] {
        W_VIC_LO = 2'd0,
        W_VIC_HI = 2'd1,
        W_AGG_LO = 2'd2,
        W_AGG_HI = 2'd3
    } word_sel_e;

    typedef struct packed {
        logic [PAT_W-1:0] victim;
        logic [PAT_W-1:0] aggressor;
        logic             basic;
    } pat_set_t;

    typedef struct packed {
        logic             active;
        logic [VIC_W-1:0] vic_idx;
        logic [BEAT_W-1:0] beat;
    } seq_pos_t;

    function automatic logic [WORD_W-1:0] word_reset(input int unsigned sel);
        case (sel)
            0:       return VIC_LO_RST;
            1:       return VIC_HI_RST;
            2:       return AGG_LO_RST;
            default: return AGG_HI_RST;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] rise_bit(input logic [BEAT_W-1:0] beat);
        return IDX_W'(PAT_W - 1) - {beat, 1'b0};
    endfunction
endpackage

// File: rtl/calpat_regs.sv
module calpat_regs
    import calpat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              load,
    input  logic              basic_in,
    output pat_set_t          run_set
);
    logic [WORD_W-1:0] prog_q [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                prog_q[g] <= word_reset(g);
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                prog_q[g] <= wr_data;
        end
    end

    pat_set_t next_set;
    always_comb begin
        next_set.victim    = {prog_q[W_VIC_HI], prog_q[W_VIC_LO]};
        next_set.aggressor = {prog_q[W_AGG_HI], prog_q[W_AGG_LO]};
        next_set.basic     = basic_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_set.victim    <= {VIC_HI_RST, VIC_LO_RST};
            run_set.aggressor <= {AGG_HI_RST, AGG_LO_RST};
            run_set.basic     <= 1'b0;
        end else if (load) begin
            run_set <= next_set;
        end
    end
endmodule

// File: rtl/calpat_seq.sv
module calpat_seq
    import calpat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output logic     load,
    output seq_pos_t pos,
    output logic     done
);
    seq_pos_t pos_q;
    logic     done_q;
    logic     burst_end;
    logic     run_end;

    assign load      = start && !pos_q.active;
    assign burst_end = (pos_q.beat == BEAT_W'(BURST_CLKS - 1));
    assign run_end   = pos_q.active && burst_end && (pos_q.vic_idx == VIC_W'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= run_end;
            if (load) begin
                pos_q.active  <= 1'b1;
                pos_q.vic_idx <= '0;
                pos_q.beat    <= '0;
            end else if (pos_q.active) begin
                if (run_end) begin
                    pos_q.active <= 1'b0;
                    pos_q.beat   <= '0;
                    pos_q.vic_idx <= '0;
                end else begin
                    pos_q.beat <= pos_q.beat + BEAT_W'(1);
                    if (burst_end)
                        pos_q.vic_idx <= pos_q.vic_idx + VIC_W'(1);
                end
            end
        end
    end

    assign pos  = pos_q;
    assign done = done_q;
endmodule

// File: rtl/calpat_lanes.sv
module calpat_lanes
    import calpat_pkg::*;
#(
    parameter int LANES = 9
) (
    input  pat_set_t                 run_set,
    input  seq_pos_t                 pos,
    output logic [LANES*BYTE_W-1:0]  dq_rise,
    output logic [LANES*BYTE_W-1:0]  dq_fall
);
    logic [IDX_W-1:0] r_idx;
    logic [IDX_W-1:0] f_idx;
    logic vic_r, vic_f, agg_r, agg_f;

    assign r_idx = rise_bit(pos.beat);
    assign f_idx = r_idx - IDX_W'(1);
    assign vic_r = run_set.victim[r_idx];
    assign vic_f = run_set.victim[f_idx];
    assign agg_r = run_set.aggressor[r_idx];
    assign agg_f = run_set.aggressor[f_idx];

    logic [BYTE_W-1:0] lane_r;
    logic [BYTE_W-1:0] lane_f;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        logic is_vic;
        assign is_vic = (pos.vic_idx == VIC_W'(b));
        always_comb begin
            if (!pos.active) begin
                lane_r[b] = 1'b0;
                lane_f[b] = 1'b0;
            end else if (run_set.basic) begin
                lane_r[b] = 1'b1;
                lane_f[b] = 1'b0;
            end else begin
                lane_r[b] = is_vic ? vic_r : agg_r;
                lane_f[b] = is_vic ? vic_f : agg_f;
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign dq_rise[l*BYTE_W +: BYTE_W] = lane_r;
        assign dq_fall[l*BYTE_W +: BYTE_W] = lane_f;
    end
endmodule

// File: rtl/calpat_gen.sv
module calpat_gen
    import calpat_pkg::*;
#(
    parameter int LANES = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [1:0]               wr_addr,
    input  logic [31:0]              wr_data,
    input  logic                     basic_sel,
    input  logic                     start,
    output logic                     valid,
    output logic                     done,
    output logic [LANES*8-1:0]       dq_rise,
    output logic [LANES*8-1:0]       dq_fall
);
    pat_set_t run_set;
    seq_pos_t pos;
    logic     load;
    logic     basic_live;

    calpat_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .pos   (pos),
        .done  (done)
    );

    calpat_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .load     (load),
        .basic_in (basic_sel),
        .run_set  (run_set)
    );

    calpat_lanes #(.LANES(LANES)) u_lanes (
        .run_set (run_set),
        .pos     (pos),
        .dq_rise (dq_rise),
        .dq_fall (dq_fall)
    );

    assign valid      = pos.active;
    assign basic_live = run_set.basic;
endmodule

// File: rtl/calpat_chk.sv
module calpat_chk #(
    parameter int LANES = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               valid,
    input logic               done,
    input logic               basic_live,
    input logic [LANES*8-1:0] dq_rise,
    input logic [LANES*8-1:0] dq_fall
);
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!valid && $past(valid)));

    // R4
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> (valid || done));

    // R9
    restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && start) |=> (valid || done));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (dq_rise == '0 && dq_fall == '0));

    // R7
    basic_level_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && basic_live) |-> ((&dq_rise) && dq_fall == '0));

    for (genvar l = 1; l < LANES; l++) begin : g_lane_chk
        // R6
        lane_match_chk: assert property (@(posedge clk) disable iff (rst)
            valid |-> (dq_rise[l*8 +: 8] == dq_rise[7:0] &&
                       dq_fall[l*8 +: 8] == dq_fall[7:0]));
    end
endmodule

bind calpat_gen calpat_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .valid      (valid),
    .done       (done),
    .basic_live (basic_live),
    .dq_rise    (dq_rise),
    .dq_fall    (dq_fall)
);

// File: tb/tb_calpat_gen.sv
module tb_calpat_gen;
    localparam int LANES = 9;
    localparam int W     = LANES * 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         basic_sel = 1'b0;
    logic         start = 1'b0;
    logic         valid;
    logic         done;
    logic [W-1:0] dq_rise;
    logic [W-1:0] dq_fall;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    calpat_gen #(.LANES(LANES)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .basic_sel(basic_sel), .start(start), .valid(valid), .done(done),
        .dq_rise(dq_rise), .dq_fall(dq_fall)
    );

    logic [63:0] mid_vic;
    logic [63:0] mid_agg;

    task automatic chk(input bit ok, input string tag, input logic [2*W+1:0] act, input logic [2*W+1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_beat(input logic [63:0] v, input logic [63:0] a,
                                              input int vi, input int idx, input bit bas, input bit rise);
        logic [W-1:0] r;
        for (int l = 0; l < LANES; l++)
            for (int b = 0; b < 8; b++)
                r[l*8+b] = bas ? rise : ((b == vi) ? v[idx] : a[idx]);
        return r;
    endfunction

    task automatic write_word(input logic [1:0] ad, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ad; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        logic [2*W+1:0] act;
        act = {valid, done, dq_rise, dq_fall};
        chk(act == '0, tag, act, '0);
    endtask

    // act: 0 none, 1 four pattern writes at run clocks 100..103, 2 start pulse at clock 100
    task automatic run_seq(input logic [63:0] ev, input logic [63:0] ea, input bit bas,
                           input int act, input string tag);
        logic [2*W+1:0] got, want;
        int errs;
        errs = 0;
        @(negedge clk);
        start = 1'b1; basic_sel = bas;
        @(negedge clk);
        start = 1'b0; basic_sel = ~bas;
        for (int c = 0; c < 256; c++) begin
            int vi, k;
            vi = c / 32; k = c % 32;
            got  = {valid, done, dq_rise, dq_fall};
            want = {1'b1, 1'b0, exp_beat(ev, ea, vi, 63 - 2*k, bas, 1'b1),
                                exp_beat(ev, ea, vi, 62 - 2*k, bas, 1'b0)};
            if (got !== want) begin
                errs++;
                if (errs < 4) chk(1'b0, tag, got, want);
            end
            if (act == 1 && c >= 100 && c < 104) begin
                wr_en = 1'b1;
                wr_addr = 2'(c - 100);
                case (c - 100)
                    0: wr_data = mid_vic[31:0];
                    1: wr_data = mid_vic[63:32];
                    2: wr_data = mid_agg[31:0];
                    default: wr_data = mid_agg[63:32];
                endcase
            end else begin
                wr_en = 1'b0;
            end
            start = (act == 2 && c == 100);
            @(negedge clk);
        end
        wr_en = 1'b0; start = 1'b0; basic_sel = 1'b0;
        chk(errs == 0, {tag, " whole-run beats"}, '0, '0);
        // R5: done exactly in the clock after the last valid clock
        got = {valid, done, dq_rise, dq_fall};
        want = {1'b0, 1'b1, {W{1'b0}}, {W{1'b0}}};
        chk(got === want, "R5 done pulse", got, want);
        @(negedge clk);
        check_idle("R5/R10 idle after done");
    endtask

    task automatic t_reset();
        check_idle("R10 reset state");
    endtask

    task automatic t_defaults();
        run_seq({32'h6666_9999, 32'hAAAA_0A05}, {32'h0F0F_3C3C, 32'hC3C3_F0F0}, 1'b0, 0,
                "R1/R2/R3/R4/R6 defaults");
    endtask

    task automatic t_program();
        write_word(2'd0, 32'h1234_5678);
        write_word(2'd1, 32'h8000_0001);
        write_word(2'd2, 32'hFFFF_0000);
        write_word(2'd3, 32'h0000_FFFF);
        check_idle("R10 idle after writes");
        run_seq(64'h8000_0001_1234_5678, 64'h0000_FFFF_FFFF_0000, 1'b0, 0, "R2/R3 programmed");
    endtask

    task automatic t_midwrite();
        mid_vic = 64'hFEDC_BA98_7654_3210;
        mid_agg = 64'h0123_4567_89AB_CDEF;
        run_seq(64'h8000_0001_1234_5678, 64'h0000_FFFF_FFFF_0000, 1'b0, 1, "R8 old patterns kept");
        run_seq(mid_vic, mid_agg, 1'b0, 0, "R8 new patterns at next start");
    endtask

    task automatic t_restart();
        run_seq(mid_vic, mid_agg, 1'b0, 2, "R9 start during run");
    endtask

    task automatic t_basic();
        run_seq(mid_vic, mid_agg, 1'b1, 0, "R7 basic pattern");
        run_seq(mid_vic, mid_agg, 1'b0, 0, "R7 back to programmed");
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        $display("FAIL watchdog R4 actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_defaults();
        t_program();
        t_midwrite();
        t_restart();
        t_basic();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule